// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the byte-wide command and status port of a single eight-line interrupt controller. A one-bit address picks between two registers. Software uses this port to walk the controller through its start-up word sequence, to load the line mask, to retire in-service lines by end-of-interrupt commands, to rotate line priority, and to read back the request, in-service and mask registers or a polled winner.

The request and in-service registers themselves live in the neighbouring capture logic. They arrive here as plain inputs (`irr_in`, `isr_in`). This block drives one-cycle clear strobes back to the capture logic. It also drives the mask, the vector base, the mode flags and the priority offset that the rest of the controller uses.

A write and a read each take one clock of a simple synchronous strobe. Priority is rotating. The line with the highest priority is line `prio_off`, followed by `prio_off+1`, and so on, all modulo 8.

Top module: `pic_cmd_port`

## Requirements
- R1: A write to address 0 with data bit 4 set starts initialisation. Bit 0 of that write is stored as "mode word expected". On the next clock, the mask, the priority offset, the special-mask flag and the read select are zero, and `init_phase` is 1.
- R2: In phase 1, a write to address 1 sets `vec_base` to the data AND 8'hF8 and moves to phase 2.
- R3: In phase 2, a write to address 1 moves to phase 3 if a mode word is expected, and to phase 0 (normal) otherwise.
- R4: In phase 3, a write to address 1 sets `sfnm` from data bit 4 and `aeoi` from data bit 1, then returns to phase 0.
- R5: In phase 0, a write to address 1 loads the mask. A read from address 1 (no poll pending) returns the mask. In phases 1 to 3, a write to address 1 leaves the mask unchanged.
- R6: A write to address 0 with bit 4 = 0 and bit 3 = 1 is a control word. Bit 2 = 1 arms a poll. Bit 1 = 1 copies bit 0 into the read select. Bit 6 = 1 copies bit 5 into `smask`. A read from address 0 with no poll pending returns `isr_in` when the read select is 1, and `irr_in` when it is 0.
- R7: A write to address 0 with bits 4 and 3 both 0 is a command, and data bits 7:5 select it. Value 1 pulses `isr_clr` for the in-service line with the highest priority, during the write cycle. Value 5 does the same and also sets `prio_off` to that line + 1. If no line is in service, neither command has any effect.
- R8: Command value 3 pulses `isr_clr` for the line in bits 2:0. Value 7 does the same and sets `prio_off` to that line + 1. Value 6 sets `prio_off` to bits 2:0 + 1. Values 0 and 4 clear or set `rot_aeoi`. Value 2 changes nothing. `prio_off` changes only on a write.
- R9: A read while a poll is armed returns {5'b0, line} for the winner. The winner is the unmasked request line with the highest priority, provided its priority is strictly higher than that of every in-service line. In the first read cycle, the read pulses both `irr_clr` and `isr_clr` for the winner. If there is no winner, the read returns 8'h07 and pulses no strobe. The poll is disarmed after the read.
- R10: The start of initialisation clears `aeoi` and `sfnm` only when bit 0 of the start word is 0. Otherwise both keep their values until the mode word arrives.
- R11: Read data is captured in the first cycle of a read. It appears on the next clock and stays constant while `rd_en` stays high.
- R12: A poll read and an end-of-interrupt write in the same cycle produce the bitwise OR of both clear strobes on `isr_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe; held high to keep read data |
| addr | input | 1 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| irr_in | input | 8 | Request register from capture logic |
| isr_in | input | 8 | In-service register from capture logic |
| imr_out | output | 8 | Line mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| init_phase | output | 2 | 0 normal, 1 to 3 initialisation steps |
| sfnm | output | 1 | Special fully nested mode |
| aeoi | output | 1 | Automatic end of interrupt |
| rot_aeoi | output | 1 | Rotate on automatic end of interrupt |
| smask | output | 1 | Special mask mode |
| prio_off | output | 3 | Line with the highest priority |
| isr_clr | output | 8 | In-service clear strobes |
| irr_clr | output | 8 | Request clear strobes (poll) |

## Verification
The two functions that can land in one cycle are a poll read and an end-of-interrupt write. Both pull bits out of the in-service register through the same `isr_clr` strobe. The bench provokes the overlap by raising `rd_en` with a poll armed and `wr_en` with a non-specific end-of-interrupt command in the same cycle. It chooses an in-service set whose top line differs from the poll winner. It then requires `isr_clr` to carry both lines and `irr_clr` to carry only the winner. The read data must name the winner, computed from the priority offset as it stood before the write.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  localparam int NLINES = 8;
  localparam int LW = $clog2(NLINES);
  localparam int RW = LW + 1;

  typedef enum logic [1:0] {
    PH_RUN     = 2'd0,
    PH_BASE    = 2'd1,
    PH_CASCADE = 2'd2,
    PH_MODE    = 2'd3
  } init_phase_t;

  // rank of the highest-priority set bit; NLINES when empty
  function automatic logic [RW-1:0] rank_of(input logic [NLINES-1:0] m,
                                            input logic [LW-1:0] off);
    logic [2*NLINES-1:0] dbl;
    logic [RW-1:0] r;
    dbl = {m, m} >> off;
    r = RW'(NLINES);
    for (int k = NLINES - 1; k >= 0; k--)
      if (dbl[k]) r = RW'(k);
    return r;
  endfunction

  function automatic logic [LW-1:0] line_of(input logic [RW-1:0] rank,
                                            input logic [LW-1:0] off);
    return rank[LW-1:0] + off;
  endfunction

  function automatic logic [NLINES-1:0] onehot(input logic [LW-1:0] line);
    return NLINES'(1) << line;
  endfunction
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] BASE_MASK = 8'hF8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic          init_start,
  output init_phase_t   phase,
  output logic [DW-1:0] imr,
  output logic [DW-1:0] base,
  output logic          sfnm,
  output logic          aeoi
);
  logic need4;
  logic data_wr;

  assign init_start = wr_en && !addr && wdata[4];
  assign data_wr    = wr_en && addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_RUN;
      imr   <= '0;
      base  <= '0;
      need4 <= 1'b0;
      sfnm  <= 1'b0;
      aeoi  <= 1'b0;
    end else if (init_start) begin
      need4 <= wdata[0];
      imr   <= '0;
      phase <= PH_BASE;
      if (!wdata[0]) begin
        sfnm <= 1'b0;
        aeoi <= 1'b0;
      end
    end else if (data_wr) begin
      unique case (phase)
        PH_RUN:  imr <= wdata;
        PH_BASE: begin
          base  <= wdata & BASE_MASK;
          phase <= PH_CASCADE;
        end
        PH_CASCADE: phase <= need4 ? PH_MODE : PH_RUN;
        PH_MODE: begin
          sfnm  <= wdata[4];
          aeoi  <= wdata[1];
          phase <= PH_RUN;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end
endmodule

// File: rtl/pic_op_cmd.sv
module pic_op_cmd
  import pic_cmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DW-1:0]     wdata,
  input  logic              init_start,
  input  logic              rd_first,
  input  logic [NLINES-1:0] isr_vec,
  output logic [LW-1:0]     prio_off,
  output logic              rot_aeoi,
  output logic              smask,
  output logic              rsel,
  output logic              poll_pend,
  output logic [NLINES-1:0] eoi_clr
);
  logic          ctl_wr, cmd_wr;
  logic [2:0]    cmd;
  logic [LW-1:0] named;
  logic [RW-1:0] top_rank;
  logic [LW-1:0] top_line;
  logic          top_any;

  assign ctl_wr   = wr_en && !addr && !wdata[4] && wdata[3];
  assign cmd_wr   = wr_en && !addr && !wdata[4] && !wdata[3];
  assign cmd      = wdata[7:5];
  assign named    = wdata[LW-1:0];
  assign top_rank = rank_of(isr_vec, prio_off);
  assign top_line = line_of(top_rank, prio_off);
  assign top_any  = (top_rank != RW'(NLINES));

  always_comb begin
    eoi_clr = '0;
    if (cmd_wr) begin
      unique case (cmd)
        3'd1, 3'd5: if (top_any) eoi_clr = onehot(top_line);
        3'd3, 3'd7: eoi_clr = onehot(named);
        default:    eoi_clr = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_off  <= '0;
      rot_aeoi  <= 1'b0;
      smask     <= 1'b0;
      rsel      <= 1'b0;
      poll_pend <= 1'b0;
    end else begin
      if (rd_first) poll_pend <= 1'b0;
      if (init_start) begin
        prio_off <= '0;
        smask    <= 1'b0;
        rsel     <= 1'b0;
      end else if (ctl_wr) begin
        if (wdata[2]) poll_pend <= 1'b1;
        if (wdata[1]) rsel <= wdata[0];
        if (wdata[6]) smask <= wdata[5];
      end else if (cmd_wr) begin
        unique case (cmd)
          3'd0, 3'd4: rot_aeoi <= cmd[2];
          3'd5:       if (top_any) prio_off <= top_line + 1'b1;
          3'd6, 3'd7: prio_off <= named + 1'b1;
          default:    ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_readback.sv
module pic_readback
  import pic_cmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              addr,
  input  logic              poll_pend,
  input  logic              rsel,
  input  logic [LW-1:0]     prio_off,
  input  logic [NLINES-1:0] irr_vec,
  input  logic [NLINES-1:0] isr_vec,
  input  logic [NLINES-1:0] imr,
  output logic              rd_first,
  output logic              rd_held,
  output logic [NLINES-1:0] poll_clr,
  output logic [DW-1:0]     rdata
);
  logic [RW-1:0] req_rank, svc_rank;
  logic [LW-1:0] win_line;
  logic          win_hit;
  logic [DW-1:0] rd_next;

  assign rd_first = rd_en && !rd_held;
  assign req_rank = rank_of(irr_vec & ~imr, prio_off);
  assign svc_rank = rank_of(isr_vec, prio_off);
  assign win_hit  = (req_rank < svc_rank);
  assign win_line = line_of(req_rank, prio_off);
  assign poll_clr = (rd_first && poll_pend && win_hit) ? onehot(win_line) : '0;

  always_comb begin
    if (poll_pend)  rd_next = win_hit ? DW'(win_line) : DW'(NLINES - 1);
    else if (addr)  rd_next = DW'(imr);
    else if (rsel)  rd_next = DW'(isr_vec);
    else            rd_next = DW'(irr_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_held <= 1'b0;
      rdata   <= '0;
    end else begin
      rd_held <= rd_en;
      if (rd_first) rdata <= rd_next;
    end
  end
endmodule

// File: rtl/pic_cmd_port.sv
module pic_cmd_port
  import pic_cmd_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] BASE_MASK = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NLINES-1:0] irr_in,
  input  logic [NLINES-1:0] isr_in,
  output logic [NLINES-1:0] imr_out,
  output logic [DW-1:0]     vec_base,
  output logic [1:0]        init_phase,
  output logic              sfnm,
  output logic              aeoi,
  output logic              rot_aeoi,
  output logic              smask,
  output logic [LW-1:0]     prio_off,
  output logic [NLINES-1:0] isr_clr,
  output logic [NLINES-1:0] irr_clr
);
  // named internal events, visible to the bound checker
  logic              init_start;
  logic              rd_first;
  logic              rd_held;
  logic              poll_pend;
  logic              rsel;
  logic [NLINES-1:0] eoi_clr;
  logic [NLINES-1:0] poll_clr;
  init_phase_t       phase;
  logic [DW-1:0]     imr_w;

  pic_init_seq #(.DW(DW), .BASE_MASK(BASE_MASK)) u_init (
    .clk, .rst_n, .wr_en, .addr, .wdata,
    .init_start (init_start),
    .phase      (phase),
    .imr        (imr_w),
    .base       (vec_base),
    .sfnm       (sfnm),
    .aeoi       (aeoi)
  );

  pic_op_cmd #(.DW(DW)) u_cmd (
    .clk, .rst_n, .wr_en, .addr, .wdata,
    .init_start (init_start),
    .rd_first   (rd_first),
    .isr_vec    (isr_in),
    .prio_off   (prio_off),
    .rot_aeoi   (rot_aeoi),
    .smask      (smask),
    .rsel       (rsel),
    .poll_pend  (poll_pend),
    .eoi_clr    (eoi_clr)
  );

  pic_readback #(.DW(DW)) u_rd (
    .clk, .rst_n, .rd_en, .addr,
    .poll_pend  (poll_pend),
    .rsel       (rsel),
    .prio_off   (prio_off),
    .irr_vec    (irr_in),
    .isr_vec    (isr_in),
    .imr        (imr_out),
    .rd_first   (rd_first),
    .rd_held    (rd_held),
    .poll_clr   (poll_clr),
    .rdata      (rdata)
  );

  assign imr_out    = imr_w[NLINES-1:0];
  assign init_phase = phase;
  assign isr_clr    = eoi_clr | poll_clr;
  assign irr_clr    = poll_clr;
endmodule

// File: rtl/pic_cmd_port_chk.sv
module pic_cmd_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] imr_out,
  input logic [7:0] vec_base,
  input logic [1:0] init_phase,
  input logic       smask,
  input logic [2:0] prio_off,
  input logic [7:0] isr_clr,
  input logic [7:0] irr_clr,
  input logic       rd_held,
  input logic       poll_pend
);
  assert_init_enter_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=>
      (init_phase == 2'd1 && imr_out == 8'h00 && prio_off == 3'd0 && !smask));

  assert_base_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_base[2:0] == 3'b000);

  assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (init_phase == 2'd2 && wr_en && addr && !(!addr && wdata[4])) |=>
      (init_phase == 2'd0 || init_phase == 2'd3));

  assert_off_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(prio_off));

  assert_poll_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr_clr & ~isr_clr) == 8'h00) && $countones(irr_clr) <= 1);

  assert_poll_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !rd_held && poll_pend) |-> irr_clr == 8'h00);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_held) |=> $stable(rdata));

  assert_one_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> $onehot0(isr_clr));
endmodule

bind pic_cmd_port pic_cmd_port_chk u_chk (
  .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata, .imr_out, .vec_base,
  .init_phase, .smask, .prio_off, .isr_clr, .irr_clr,
  .rd_held (rd_held), .poll_pend (poll_pend)
);

// File: tb/pic_cmd_port_test.sv
module pic_cmd_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, irr_in = '0, isr_in = '0;
  logic [7:0] rdata, imr_out, vec_base, isr_clr, irr_clr;
  logic [1:0] init_phase;
  logic       sfnm, aeoi, rot_aeoi, smask;
  logic [2:0] prio_off;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] seen_isr_clr, seen_irr_clr, rd_val;

  always #10 clk = ~clk;

  pic_cmd_port uut (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata, .irr_in, .isr_in,
    .imr_out, .vec_base, .init_phase, .sfnm, .aeoi, .rot_aeoi, .smask,
    .prio_off, .isr_clr, .irr_clr
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference priority: lowest distance from the offset, 8 when empty
  function automatic int ref_rank(input logic [7:0] m, input int off);
    int r = 8;
    for (int k = 0; k < 8; k++)
      if (r == 8 && m[(k + off) % 8]) r = k;
    return r;
  endfunction

  task automatic do_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    #5 seen_isr_clr = isr_clr; seen_irr_clr = irr_clr;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #5 seen_isr_clr = isr_clr; seen_irr_clr = irr_clr;
    @(negedge clk);
    rd_val = rdata;
    rd_en = 1'b0;
  endtask

  task automatic set_off(input int off);
    do_wr(1'b0, 8'hC0 | 8'((off + 7) % 8));
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("reset imr", imr_out, 0);
    chk("reset base", vec_base, 0);
    chk("reset phase", init_phase, 0);
    chk("reset off", prio_off, 0);
    chk("reset flags", {sfnm, aeoi, rot_aeoi, smask}, 0);
    chk("reset rdata", rdata, 0);

    // R5: mask load and readback sweep
    for (int v = 0; v < 256; v++) begin
      do_wr(1'b1, 8'(v));
      chk("R5 mask out", imr_out, v);
      do_rd(1'b1);
      chk("R5 mask read", rd_val, v);
    end

    // R1 / R2 / R3 / R4 / R10 initialisation sequences
    do_wr(1'b1, 8'hA5); set_off(5); do_wr(1'b0, 8'h68); do_wr(1'b0, 8'h0B);
    do_wr(1'b0, 8'h11);
    chk("R1 phase", init_phase, 1);
    chk("R1 mask", imr_out, 0);
    chk("R1 off", prio_off, 0);
    chk("R1 smask", smask, 0);
    isr_in = 8'h3C; irr_in = 8'hC3;
    do_rd(1'b0);
    chk("R1 rsel cleared", rd_val, 8'hC3);
    do_wr(1'b1, 8'h77);
    chk("R2 base", vec_base, 8'h70);
    chk("R5 mask untouched in init", imr_out, 0);
    chk("R2 phase", init_phase, 2);
    do_wr(1'b1, 8'h04);
    chk("R3 phase to mode", init_phase, 3);
    do_wr(1'b1, 8'h12);
    chk("R4 sfnm", sfnm, 1);
    chk("R4 aeoi", aeoi, 1);
    chk("R4 phase", init_phase, 0);
    do_wr(1'b0, 8'h11);
    chk("R10 aeoi kept", aeoi, 1);
    chk("R10 sfnm kept", sfnm, 1);
    do_wr(1'b1, 8'hFF);
    chk("R2 base max", vec_base, 8'hF8);
    do_wr(1'b1, 8'h00);
    do_wr(1'b1, 8'h02);
    chk("R4 aeoi only", {sfnm, aeoi}, 2'b01);
    do_wr(1'b0, 8'h10);
    chk("R10 cleared", {sfnm, aeoi}, 2'b00);
    for (int b = 0; b < 256; b += 29) begin
      do_wr(1'b1, 8'(b));
      chk("R2 base sweep", vec_base, b & 8'hF8);
      do_wr(1'b1, 8'h00);
      chk("R3 phase to run", init_phase, 0);
      do_wr(1'b0, 8'h11);
      do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h00);
      do_wr(1'b1, 8'h10);
      chk("R4 sfnm only", {sfnm, aeoi}, 2'b10);
      do_wr(1'b0, 8'h10);
    end
    do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h00);
    chk("R3 back to run", init_phase, 0);

    // R6 control words
    isr_in = 8'h5A; irr_in = 8'h81;
    do_wr(1'b0, 8'h0B); do_rd(1'b0);
    chk("R6 read isr", rd_val, 8'h5A);
    do_wr(1'b0, 8'h09); do_rd(1'b0);
    chk("R6 rsel needs bit1", rd_val, 8'h5A);
    do_wr(1'b0, 8'h0A); do_rd(1'b0);
    chk("R6 read irr", rd_val, 8'h81);
    do_wr(1'b0, 8'h68);
    chk("R6 smask set", smask, 1);
    do_wr(1'b0, 8'h28);
    chk("R6 smask needs bit6", smask, 1);
    do_wr(1'b0, 8'h48);
    chk("R6 smask clear", smask, 0);

    // R7 non-specific end of interrupt sweep
    for (int off = 0; off < 8; off++) begin
      set_off(off);
      chk("R8 set offset", prio_off, off);
      for (int s = 0; s < 256; s++) begin
        int r;
        isr_in = 8'(s);
        r = ref_rank(8'(s), off);
        do_wr(1'b0, 8'h20);
        chk("R7 eoi clear", seen_isr_clr, (r == 8) ? 0 : (1 << ((r + off) % 8)));
        chk("R7 eoi no irr", seen_irr_clr, 0);
      end
    end
    for (int s = 0; s < 256; s += 13) begin
      int r;
      set_off(s % 8);
      isr_in = 8'(s);
      r = ref_rank(8'(s), s % 8);
      do_wr(1'b0, 8'hA0);
      chk("R7 rotate eoi clear", seen_isr_clr, (r == 8) ? 0 : (1 << ((r + s % 8) % 8)));
      chk("R7 rotate eoi off", prio_off, (r == 8) ? (s % 8) : ((r + s % 8 + 1) % 8));
    end

    // R8 specific commands
    isr_in = 8'hFF;
    for (int l = 0; l < 8; l++) begin
      set_off(2);
      do_wr(1'b0, 8'h60 | 8'(l));
      chk("R8 specific clear", seen_isr_clr, 1 << l);
      chk("R8 specific keeps off", prio_off, 2);
      do_wr(1'b0, 8'hE0 | 8'(l));
      chk("R8 rotate specific clear", seen_isr_clr, 1 << l);
      chk("R8 rotate specific off", prio_off, (l + 1) % 8);
    end
    do_wr(1'b0, 8'h80);
    chk("R8 rot_aeoi set", rot_aeoi, 1);
    set_off(4);
    do_wr(1'b0, 8'h40);
    chk("R8 nop clear", seen_isr_clr, 0);
    chk("R8 nop off", prio_off, 4);
    chk("R8 nop rot", rot_aeoi, 1);
    do_wr(1'b0, 8'h00);
    chk("R8 rot_aeoi clear", rot_aeoi, 0);

    // R9 poll sweep
    for (int mk = 0; mk < 2; mk++) begin
      do_wr(1'b1, mk ? 8'h24 : 8'h00);
      for (int off = 0; off < 8; off++) begin
        set_off(off);
        for (int q = 0; q < 256; q++) begin
          int rr, ri, ln;
          logic [7:0] sv;
          sv = 8'(1 << ((q * 3 + off) % 8)) & 8'(q * 7);
          irr_in = 8'(q); isr_in = sv;
          rr = ref_rank(8'(q) & ~(mk ? 8'h24 : 8'h00), off);
          ri = ref_rank(sv, off);
          ln = (rr + off) % 8;
          do_wr(1'b0, 8'h0C);
          do_rd(q[0]);
          chk("R9 poll data", rd_val, (rr < ri) ? ln : 7);
          chk("R9 poll irr clr", seen_irr_clr, (rr < ri) ? (1 << ln) : 0);
          chk("R9 poll isr clr", seen_isr_clr, (rr < ri) ? (1 << ln) : 0);
        end
      end
    end
    do_wr(1'b1, 8'h5C);
    do_rd(1'b1);
    chk("R9 poll disarmed", rd_val, 8'h5C);

    // R11 read data held while rd_en stays high
    irr_in = 8'h33; do_wr(1'b0, 8'h0A);
    @(negedge clk); rd_en = 1'b1; addr = 1'b0;
    @(negedge clk);
    chk("R11 first data", rdata, 8'h33);
    irr_in = 8'hCC;
    repeat (3) @(negedge clk);
    chk("R11 held", rdata, 8'h33);
    rd_en = 1'b0;

    // R12 poll read and eoi write in one cycle
    do_wr(1'b1, 8'h00); set_off(0);
    irr_in = 8'h02; isr_in = 8'h30;
    do_wr(1'b0, 8'h0C);
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = 1'b0; wdata = 8'h20;
    #5;
    chk("R12 isr clr merged", isr_clr, 8'h12);
    chk("R12 irr clr", irr_clr, 8'h02);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R12 poll data", rdata, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule